// File: doc/BRIEF.md
# Mode-Addressed Port Configuration and Wake-Up Unit

This unit holds the per-pin configuration of one 8-bit I/O port and watches its inputs for wake-up events. Software never addresses the configuration registers directly. It first loads a small mode pointer. A later port-control write then lands in whichever hidden register that pointer selects. The hidden registers control pin direction, input threshold, pull-up, Schmitt trigger, wake-up edge polarity and wake-up enable. Each register drives its own output bus towards the pad ring.

Two pointer codes are exchanges, not plain writes. While the pointer holds one of them, the control read bus shows the current contents of the target register. A write then replaces those contents with the supplied value. With the pending-event register as the target, a single access both reads and clears the flags. The second exchange target is an 8-bit comparator status/enable register.

Each input pin passes through a two-stage synchroniser before an edge detector. A detected edge that matches the pin's selected polarity, on a pin whose wake-up is enabled, latches a pending flag. Any enabled pending flag raises an interrupt request while the core runs, or a wake request while it sleeps.

Top module: `port_wake_unit`

## Requirements
- R1: After reset, the direction, pull-up, level, Schmitt and wake-enable outputs are all ones, the wake-edge output is all zeros, the pending and comparator registers read zero, and both requests are low.
- R2: A port-control write reaches one register, chosen by the low nibble of the mode pointer: 0xF direction (1 = input), 0xE pull-up (0 = enabled), 0xD level (0 = TTL, 1 = CMOS), 0xC Schmitt (0 = enabled), 0xA wake edge (0 = falling, 1 = rising), 0xB wake enable (0 = enabled). The new value appears on the register's output after the next rising clock edge.
- R3: The upper four bits of the mode value are ignored. For example, 0x3F selects the same register as 0x0F.
- R4: A port-control write with the pointer at any code 0x0–0x7 changes no register and no output.
- R5: With the pointer at 0x9, the read bus shows the pending flags combinationally. A write with the pointer at 0x9 loads the written value into the pending register, so writing zero clears it.
- R6: With the pointer at 0x8, the read bus shows the comparator register. A write with the pointer at 0x8 loads the written value into that register.
- R7: A pin whose wake-enable bit is 0 sets its pending bit on the selected edge. The bit becomes visible after the third rising clock edge that follows the pin change. The opposite edge sets nothing.
- R8: A pin whose wake-enable bit is 1 never sets its pending bit.
- R9: A pending bit stays set until a pending exchange overwrites it. An event that arrives in the same cycle as a pending exchange write is merged into the written value and is not lost.
- R10: The interrupt request is high when any pending bit with wake-enable 0 is set and the sleep input is low. The wake request is high under the same pending condition when the sleep input is high. A pending bit whose enable is 1 raises neither request.
- R11: When the pointer is not an exchange code, the read bus is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset (any reset cause) |
| modeWe | input | 1 | Load the mode pointer from modeIn |
| modeIn | input | 8 | Mode value; only bits 3:0 are kept |
| ctlWe | input | 1 | Port-control write strobe |
| ctlData | input | 8 | Port-control write data |
| ctlRdData | output | 8 | Exchange read data; zero for non-exchange codes |
| pinIn | input | 8 | Asynchronous port inputs |
| asleep | input | 1 | Core is in power-down |
| dirOut | output | 8 | Direction, 1 = input |
| pullOut | output | 8 | Pull-up control, 0 = enabled |
| levelOut | output | 8 | Threshold select, 0 = TTL, 1 = CMOS |
| schmittOut | output | 8 | Schmitt-trigger control, 0 = enabled |
| wakeEdgeOut | output | 8 | Wake edge, 1 = rising |
| wakeEnOut | output | 8 | Wake enable, 0 = enabled |
| irqReq | output | 1 | Interrupt request while running |
| wakeReq | output | 1 | Wake request while asleep |

## Verification
A corrupted mode pointer or a bad decoder shows up as a wrong configuration bus one clock after the stray write. It also shows up as a nonzero read bus under a non-exchange code. A pending register that drops a bit, or that gains one from a disabled pin, shows up on the exchange read and on the request lines. It also shows up one cycle late or early against the three-edge latency of the synchroniser and detector path. A lost merge between an exchange and a coincident event shows only on the next exchange read, so the bench provokes it in the exact collision cycle.

// File: rtl/pwu_pkg.sv
package pwu_pkg;
  localparam int CFG_N  = 6;
  localparam int CODE_W = 4;

  // index of each hidden configuration register
  localparam int IDX_DIR  = 0;
  localparam int IDX_PULL = 1;
  localparam int IDX_LVL  = 2;
  localparam int IDX_SCH  = 3;
  localparam int IDX_EDGE = 4;
  localparam int IDX_WEN  = 5;

  // pointer codes (low nibble)
  localparam logic [CODE_W-1:0] CODE_CMP  = 4'h8;
  localparam logic [CODE_W-1:0] CODE_PEND = 4'h9;
  localparam logic [CODE_W-1:0] CODE_EDGE = 4'hA;
  localparam logic [CODE_W-1:0] CODE_WEN  = 4'hB;
  localparam logic [CODE_W-1:0] CODE_SCH  = 4'hC;
  localparam logic [CODE_W-1:0] CODE_LVL  = 4'hD;
  localparam logic [CODE_W-1:0] CODE_PULL = 4'hE;
  localparam logic [CODE_W-1:0] CODE_DIR  = 4'hF;

  typedef struct packed {
    logic [CFG_N-1:0] cfgSel;   // write strobe per hidden register
    logic             xchgPend; // exchange write to pending flags
    logic             xchgCmp;  // exchange write to comparator register
    logic             rdPend;   // read bus shows pending flags
    logic             rdCmp;    // read bus shows comparator register
  } pwuStrobe_t;

  // reset value of a configuration register: edge polarity clears, the rest set
  function automatic logic cfgResetBit(int idx);
    return (idx == IDX_EDGE) ? 1'b0 : 1'b1;
  endfunction
endpackage

// File: rtl/pwu_control.sv
module pwu_control
  import pwu_pkg::*;
#(
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              ctlWe,
  output pwuStrobe_t        strobe
);
  logic [CODE_W-1:0] modeCode;

  always_ff @(posedge clk) begin
    if (!rstN)       modeCode <= '0;
    else if (modeWe) modeCode <= modeIn[CODE_W-1:0];
  end

  always_comb begin
    strobe = '0;
    strobe.rdPend = (modeCode == CODE_PEND);
    strobe.rdCmp  = (modeCode == CODE_CMP);
    if (ctlWe) begin
      unique case (modeCode)
        CODE_DIR:  strobe.cfgSel[IDX_DIR]  = 1'b1;
        CODE_PULL: strobe.cfgSel[IDX_PULL] = 1'b1;
        CODE_LVL:  strobe.cfgSel[IDX_LVL]  = 1'b1;
        CODE_SCH:  strobe.cfgSel[IDX_SCH]  = 1'b1;
        CODE_EDGE: strobe.cfgSel[IDX_EDGE] = 1'b1;
        CODE_WEN:  strobe.cfgSel[IDX_WEN]  = 1'b1;
        CODE_PEND: strobe.xchgPend = 1'b1;
        CODE_CMP:  strobe.xchgCmp  = 1'b1;
        default:   ;
      endcase
    end
  end

  // R3: pointer only moves on its own load strobe
  a_r3_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    !modeWe |=> $stable(modeCode));

  // R4: low codes never produce a write strobe
  a_r4_low_code_silent: assert property (@(posedge clk) disable iff (!rstN)
    (modeCode[3] == 1'b0) |-> (strobe.cfgSel == '0 && !strobe.xchgPend && !strobe.xchgCmp));
endmodule

// File: rtl/pwu_edge_sync.sv
module pwu_edge_sync #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinIn,
  output logic [WIDTH-1:0] riseEvt,
  output logic [WIDTH-1:0] fallEvt
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] stg [SYNC_STAGES];
  logic [WIDTH-1:0] prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) stg[0] <= '0;
    else       stg[0] <= pinIn;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rstN) stg[s] <= '0;
      else       stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= '0;
    else       prevQ <= stg[LAST];
  end

  assign riseEvt = stg[LAST] & ~prevQ;
  assign fallEvt = ~stg[LAST] & prevQ;

  // R7: an edge is reported for one cycle only
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (|riseEvt) |=> ((riseEvt & $past(riseEvt)) == '0));
endmodule

// File: rtl/pwu_datapath.sv
module pwu_datapath
  import pwu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwuStrobe_t       strobe,
  input  logic [WIDTH-1:0] ctlData,
  input  logic [WIDTH-1:0] riseEvt,
  input  logic [WIDTH-1:0] fallEvt,
  input  logic             asleep,
  output logic [WIDTH-1:0] cfgQ [CFG_N],
  output logic [WIDTH-1:0] rdData,
  output logic             irqReq,
  output logic             wakeReq
);
  logic [WIDTH-1:0] pendQ;
  logic [WIDTH-1:0] cmpQ;
  logic [WIDTH-1:0] hitEvt;
  logic [WIDTH-1:0] pendNext;
  logic             anyLive;

  for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rstN)                 cfgQ[i] <= {WIDTH{cfgResetBit(i)}};
      else if (strobe.cfgSel[i]) cfgQ[i] <= ctlData;
    end

    // R4: an unselected register keeps its value
    a_r4_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.cfgSel[i] |=> $stable(cfgQ[i]));
  end

  assign hitEvt = ((riseEvt & cfgQ[IDX_EDGE]) | (fallEvt & ~cfgQ[IDX_EDGE]))
                & ~cfgQ[IDX_WEN];

  always_comb begin
    pendNext = strobe.xchgPend ? ctlData : pendQ;
    pendNext = pendNext | hitEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pendQ <= '0;
    else       pendQ <= pendNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cmpQ <= '0;
    else if (strobe.xchgCmp) cmpQ <= ctlData;
  end

  always_comb begin
    rdData = '0;
    if (strobe.rdPend)     rdData = pendQ;
    else if (strobe.rdCmp) rdData = cmpQ;
  end

  assign anyLive = |(pendQ & ~cfgQ[IDX_WEN]);
  assign irqReq  = anyLive & ~asleep;
  assign wakeReq = anyLive & asleep;

  // R9: pending bits only fall through an exchange
  a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xchgPend |=> ((pendQ & $past(pendQ)) == $past(pendQ)));

  // R8: without an exchange, newly set bits come from enabled pins only
  a_r8_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.xchgPend |=> ((pendQ & ~$past(pendQ) & $past(cfgQ[IDX_WEN])) == '0));

  // R10: the two requests never coexist
  a_r10_req_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(irqReq && wakeReq));
endmodule

// File: rtl/port_wake_unit.sv
module port_wake_unit
  import pwu_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int MODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWe,
  input  logic [MODE_W-1:0] modeIn,
  input  logic              ctlWe,
  input  logic [WIDTH-1:0]  ctlData,
  output logic [WIDTH-1:0]  ctlRdData,
  input  logic [WIDTH-1:0]  pinIn,
  input  logic              asleep,
  output logic [WIDTH-1:0]  dirOut,
  output logic [WIDTH-1:0]  pullOut,
  output logic [WIDTH-1:0]  levelOut,
  output logic [WIDTH-1:0]  schmittOut,
  output logic [WIDTH-1:0]  wakeEdgeOut,
  output logic [WIDTH-1:0]  wakeEnOut,
  output logic              irqReq,
  output logic              wakeReq
);
  pwuStrobe_t       strobe;
  logic [WIDTH-1:0] riseEvt;
  logic [WIDTH-1:0] fallEvt;
  logic [WIDTH-1:0] cfgQ [CFG_N];

  pwu_control #(.MODE_W(MODE_W)) u_control (
    .clk    (clk),
    .rstN   (rstN),
    .modeWe (modeWe),
    .modeIn (modeIn),
    .ctlWe  (ctlWe),
    .strobe (strobe)
  );

  pwu_edge_sync #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk     (clk),
    .rstN    (rstN),
    .pinIn   (pinIn),
    .riseEvt (riseEvt),
    .fallEvt (fallEvt)
  );

  pwu_datapath #(.WIDTH(WIDTH)) u_data (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .ctlData (ctlData),
    .riseEvt (riseEvt),
    .fallEvt (fallEvt),
    .asleep  (asleep),
    .cfgQ    (cfgQ),
    .rdData  (ctlRdData),
    .irqReq  (irqReq),
    .wakeReq (wakeReq)
  );

  assign dirOut      = cfgQ[IDX_DIR];
  assign pullOut     = cfgQ[IDX_PULL];
  assign levelOut    = cfgQ[IDX_LVL];
  assign schmittOut  = cfgQ[IDX_SCH];
  assign wakeEdgeOut = cfgQ[IDX_EDGE];
  assign wakeEnOut   = cfgQ[IDX_WEN];

  // R1: direction is all inputs in the first cycle after any reset
  a_r1_dir_default: assert property (@(posedge clk)
    !rstN |=> (dirOut == '1));
endmodule

// File: tb/port_wake_unit_bench.sv
module port_wake_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeWe = 1'b0;
  logic [7:0] modeIn = '0;
  logic       ctlWe = 1'b0;
  logic [7:0] ctlData = '0;
  logic [7:0] ctlRdData;
  logic [7:0] pinIn = '0;
  logic       asleep = 1'b0;
  logic [7:0] dirOut, pullOut, levelOut, schmittOut, wakeEdgeOut, wakeEnOut;
  logic       irqReq, wakeReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model of the register file
  logic [7:0] mCfg [16];
  logic [7:0] mPend, mCmp;

  always #(CLK_PERIOD/2) clk = ~clk;

  port_wake_unit u_port_wake_unit (
    .clk(clk), .rstN(rstN), .modeWe(modeWe), .modeIn(modeIn),
    .ctlWe(ctlWe), .ctlData(ctlData), .ctlRdData(ctlRdData),
    .pinIn(pinIn), .asleep(asleep),
    .dirOut(dirOut), .pullOut(pullOut), .levelOut(levelOut),
    .schmittOut(schmittOut), .wakeEdgeOut(wakeEdgeOut), .wakeEnOut(wakeEnOut),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    for (int c = 0; c < 16; c++) mCfg[c] = 8'hFF;
    mCfg[10] = 8'h00;
    mPend = '0; mCmp = '0;
  endtask

  task automatic setMode(logic [7:0] m);
    @(negedge clk); modeIn = m; modeWe = 1'b1;
    @(negedge clk); modeWe = 1'b0; #1;
  endtask

  task automatic ctlWrite(logic [7:0] d);
    @(negedge clk); ctlData = d; ctlWe = 1'b1;
    @(negedge clk); ctlWe = 1'b0; #1;
  endtask

  task automatic waitCycles(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  task automatic checkCfg(string tag);
    logic live;
    check({tag, " dir"},   dirOut,      mCfg[15]);
    check({tag, " pull"},  pullOut,     mCfg[14]);
    check({tag, " lvl"},   levelOut,    mCfg[13]);
    check({tag, " sch"},   schmittOut,  mCfg[12]);
    check({tag, " edge"},  wakeEdgeOut, mCfg[10]);
    check({tag, " wen"},   wakeEnOut,   mCfg[11]);
    live = |(mPend & ~mCfg[11]);
    check({tag, " R10 irq"},  {7'b0, irqReq},  {7'b0, live & ~asleep});
    check({tag, " R10 wake"}, {7'b0, wakeReq}, {7'b0, live & asleep});
  endtask

  task automatic readPend(string tag, logic [7:0] exp);
    check(tag, ctlRdData, exp);
  endtask

  initial begin : watchdog
    for (int w = 0; w < WATCHDOG; w++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    #1;
    checkCfg("R1 reset");
    setMode(8'h09); readPend("R1 pending zero", 8'h00);
    setMode(8'h08); readPend("R1 cmp zero", 8'h00);

    // near-exhaustive pointer sweep: every code under three upper nibbles
    for (int h = 0; h < 3; h++) begin
      for (int code = 0; code < 16; code++) begin
        logic [7:0] hiN, d, m;
        hiN = (h == 0) ? 8'h00 : (h == 1) ? 8'h50 : 8'hF0;
        m = hiN | 8'(code);
        d = 8'(code * 37 + h * 11 + 3);
        asleep = code[0];
        setMode(m);
        if (code == 9)      check("R5 exchange read", ctlRdData, mPend);
        else if (code == 8) check("R6 exchange read", ctlRdData, mCmp);
        else                check("R11 non-exchange read zero", ctlRdData, 8'h00);
        ctlWrite(d);
        if (code >= 10) mCfg[code] = d;
        else if (code == 9) mPend = d;
        else if (code == 8) mCmp = d;
        if (code < 8) checkCfg("R4 unused code");
        else if (h != 0) checkCfg("R3 upper nibble ignored");
        else checkCfg("R2 decode");
        if (code == 9) check("R5 pending loaded", ctlRdData, d);
        if (code == 8) check("R6 cmp loaded", ctlRdData, d);
      end
    end
    asleep = 1'b0;

    doReset();
    #1;
    checkCfg("R1 second reset");

    // edge detection per pin and polarity with exact latency
    for (int b = 0; b < 8; b++) begin
      for (int pol = 0; pol < 2; pol++) begin
        logic [7:0] bit1;
        bit1 = 8'(1 << b);
        setMode(8'h0A); ctlWrite(pol ? bit1 : 8'h00);
        setMode(8'h0B); ctlWrite(~bit1);
        setMode(8'h09); ctlWrite(8'h00);
        if (pol == 0) begin
          @(negedge clk); pinIn = bit1;      // opposite edge first
          waitCycles(5);
          readPend("R7 opposite edge ignored", 8'h00);
        end
        @(negedge clk); pinIn = (pol == 1) ? bit1 : 8'h00;
        waitCycles(2);
        readPend("R7 not yet after two edges", 8'h00);
        waitCycles(1);
        readPend("R7 set after third edge", bit1);
        asleep = pol[0];
        #1;
        check("R10 irq", {7'b0, irqReq}, {7'b0, ~asleep});
        check("R10 wake", {7'b0, wakeReq}, {7'b0, asleep});
        asleep = 1'b0;
        setMode(8'h0B); ctlWrite(8'hFF);
        #1;
        check("R10 disabled pending no irq", {7'b0, irqReq}, 8'h00);
        @(negedge clk); pinIn = 8'h00;
        waitCycles(4);
        setMode(8'h09);
        readPend("R9 sticky", bit1);
        ctlWrite(8'h00);
        readPend("R5 cleared by zero write", 8'h00);
      end
    end

    // R8: disabled pins produce nothing on either edge
    setMode(8'h0B); ctlWrite(8'hFF);
    setMode(8'h09);
    @(negedge clk); pinIn = 8'hFF; waitCycles(5);
    @(negedge clk); pinIn = 8'h00; waitCycles(5);
    readPend("R8 disabled pins quiet", 8'h00);

    // R9: event colliding with an exchange write survives
    setMode(8'h0A); ctlWrite(8'h01);
    setMode(8'h0B); ctlWrite(8'hFE);
    setMode(8'h09);
    @(negedge clk); pinIn = 8'h01;
    @(negedge clk);
    @(negedge clk); ctlData = 8'h00; ctlWe = 1'b1; #1;
    readPend("R9 exchange returns old flags", 8'h00);
    @(negedge clk); ctlWe = 1'b0; #1;
    readPend("R9 collided event kept", 8'h01);
    waitCycles(10);
    readPend("R9 still held", 8'h01);
    check("R10 irq from merged event", {7'b0, irqReq}, 8'h01);
    ctlWrite(8'h00);
    readPend("R5 final clear", 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule